// File: doc/BRIEF.md
# Byte-Granular Guard Request Responder

This block sits beside a transaction manager in a multi-core system. A peer node announces an intent to read or write some bytes of a memory line by broadcasting a guard request. The request carries the sender's node number, the line address, a 64-bit byte-enable mask, a read/write flag and an age stamp. The responder holds the local transaction's guard table. It checks each incoming request against that table using local state only, and it returns a Grant or Deny reply addressed to the sender one cycle later. It can accept one request on every clock.

Conflicts are decided per byte. Two readers may share bytes. A writer that overlaps any byte held by another party collides with it. Bytes of the same line that do not overlap never collide. When a collision occurs, the older stamp wins. If the local transaction is the older one, the peer receives a Deny. Otherwise the peer receives a Grant and the local transaction aborts itself. Because age decides every collision, a transaction among N contenders loses at most N-1 times.

The block also handles the local core's own guard requests. A request that an exclusively granted entry already covers completes at once, with no traffic on the network. Any other request is written into the table as pending, and the transport is told to broadcast it. The responder then counts the replies from all PEERS other nodes. If all of them grant, the guard completes. If even one denies, the local transaction aborts.

Top module: `guard_responder`

## Requirements
- R1: After reset, rsp_valid, rsp_grant, guard_ok, guard_abort, abort_lost, bcast_req and txn_active are all 0.
- R2: Every cycle with in_valid high produces exactly one reply in the next cycle: rsp_valid is 1 and rsp_dst equals that in_src. A cycle without in_valid produces no reply.
- R3: An incoming read (in_write=0) whose bytes overlap only read-held local bytes of the same line is granted (rsp_grant=1).
- R4: An incoming request whose bytes overlap local bytes of the same line, where either side is a write, is denied (rsp_grant=0) when the local stamp is strictly smaller (older) than in_stamp.
- R5: An incoming request is granted when its mask shares no byte with any local entry of that line, or when no local entry holds its line.
- R6: A colliding incoming request whose in_stamp is smaller than or equal to the local stamp is granted. In the next cycle guard_abort=1 and abort_lost=1, and txn_active drops to 0.
- R7: A local guard (lg_valid) that no exclusively granted entry covers raises bcast_req for one cycle in the next cycle.
- R8: A broadcast guard completes with a one-cycle guard_ok pulse in the cycle after the PEERS-th reply, provided every reply granted. guard_ok stays 0 before that reply.
- R9: If any reply to a broadcast guard is a deny, then after the last reply guard_abort=1, abort_lost=0 and txn_active=0. The table is cleared, so a following incoming write to a previously held line is granted.
- R10: A local guard on a line that a granted write entry holds, whose mask lies within that entry's mask, produces guard_ok in the next cycle and no bcast_req.
- R11: tx_end clears the table and the transaction: txn_active=0, and incoming requests that would have collided are granted.
- R12: Replies (rep_valid) that arrive while no broadcast guard is pending are ignored and do not count toward a later guard's PEERS replies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Start a local transaction |
| tx_stamp | input | SEQ_W | Age stamp of the starting transaction (smaller is older) |
| tx_end | input | 1 | Commit or cancel: release all guards |
| lg_valid | input | 1 | Local guard request |
| lg_slot | input | SLOT_W | Table slot for the local guard |
| lg_line | input | LINE_W | Line address of the local guard |
| lg_mask | input | 64 | Byte mask of the local guard |
| lg_write | input | 1 | Local guard is for write |
| bcast_req | output | 1 | Ask the transport to broadcast the local guard |
| rep_valid | input | 1 | Peer reply to the pending local guard |
| rep_grant | input | 1 | 1 = grant, 0 = deny |
| guard_ok | output | 1 | Local guard granted (pulse) |
| guard_abort | output | 1 | Local transaction aborted (pulse) |
| abort_lost | output | 1 | With guard_abort: 1 = lost to an older peer, 0 = denied by a peer |
| txn_active | output | 1 | Local transaction in progress |
| in_valid | input | 1 | Incoming peer guard request |
| in_src | input | ID_W | Requesting node |
| in_line | input | LINE_W | Requested line |
| in_mask | input | 64 | Requested byte mask |
| in_write | input | 1 | Request is for write |
| in_stamp | input | SEQ_W | Requester's age stamp |
| rsp_valid | output | 1 | Reply valid |
| rsp_dst | output | ID_W | Reply destination node |
| rsp_grant | output | 1 | 1 = grant, 0 = deny |

## Verification
The assertions check on every cycle that each incoming request gets exactly one reply, addressed to its sender, in the following cycle. They also check that a deny appears only while a local transaction holds guards, that an abort always leaves the transaction inactive, that a completion and an abort never coincide, and that a broadcast is only ever requested after a local guard. Whether a given reply should be Grant or Deny depends on the byte overlap, the read/write kinds and the stamp order. So do the exact completion cycle after the last of the PEERS replies, the silent completion of a covered guard, and the effect of stray replies. The bench's scenarios, together with its reference model of the guard table, are what show these.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int GUARD_MASK_W = 64;

  // Two byte sets collide when they share a byte and at least one is a write.
  function automatic logic bytes_collide(input logic [GUARD_MASK_W-1:0] a_mask,
                                         input logic a_wr,
                                         input logic [GUARD_MASK_W-1:0] b_mask,
                                         input logic b_wr);
    return (|(a_mask & b_mask)) && (a_wr || b_wr);
  endfunction
endpackage

// File: rtl/guard_table.sv
module guard_table
  import guard_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int LINE_W  = 26,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    wr_en,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [LINE_W-1:0]       wr_line,
  input  logic [GUARD_MASK_W-1:0] wr_mask,
  input  logic                    wr_excl,
  input  logic                    promote,
  input  logic [SLOT_W-1:0]       promote_slot,
  input  logic [LINE_W-1:0]       pq_line,
  input  logic [GUARD_MASK_W-1:0] pq_mask,
  input  logic                    pq_excl,
  output logic                    pq_collide,
  input  logic [LINE_W-1:0]       lq_line,
  input  logic [GUARD_MASK_W-1:0] lq_mask,
  output logic                    lq_covered
);
  logic [ENTRIES-1:0]      ent_v, ent_g, ent_x;
  logic [LINE_W-1:0]       ent_line [ENTRIES];
  logic [GUARD_MASK_W-1:0] ent_mask [ENTRIES];
  logic [ENTRIES-1:0]      coll_vec, cov_vec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign coll_vec[i] = ent_v[i] && (ent_line[i] == pq_line) &&
                         bytes_collide(ent_mask[i], ent_x[i], pq_mask, pq_excl);
    assign cov_vec[i]  = ent_v[i] && ent_g[i] && ent_x[i] && (ent_line[i] == lq_line) &&
                         ((lq_mask & ~ent_mask[i]) == '0);

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ent_v[i] <= 1'b0;
        ent_g[i] <= 1'b0;
      end else if (wr_en && wr_slot == SLOT_W'(i)) begin
        ent_v[i] <= 1'b1;
        ent_g[i] <= 1'b0;
      end else if (promote && promote_slot == SLOT_W'(i)) begin
        ent_g[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_slot == SLOT_W'(i)) begin
        ent_line[i] <= wr_line;
        ent_mask[i] <= wr_mask;
        ent_x[i]    <= wr_excl;
      end
    end
  end

  assign pq_collide = |coll_vec;
  assign lq_covered = |cov_vec;
endmodule

// File: rtl/reply_tally.sv
module reply_tally #(
  parameter int PEERS = 3,
  localparam int CNT_W = $clog2(PEERS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  input  logic rep_valid,
  input  logic rep_grant,
  output logic busy,
  output logic fin,
  output logic fin_deny
);
  logic [CNT_W-1:0] cnt;
  logic             denied;

  assign fin      = busy && rep_valid && (cnt == CNT_W'(PEERS - 1));
  assign fin_deny = fin && (denied || !rep_grant);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy   <= 1'b0;
      cnt    <= '0;
      denied <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      denied <= 1'b0;
    end else if (busy && rep_valid) begin
      if (fin) begin
        busy <= 1'b0;
      end else begin
        cnt    <= cnt + 1'b1;
        denied <= denied | ~rep_grant;
      end
    end
  end
endmodule

// File: rtl/guard_responder.sv
module guard_responder
  import guard_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int LINE_W  = 26,
  parameter int SEQ_W   = 8,
  parameter int ENTRIES = 4,
  parameter int PEERS   = 3,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tx_begin,
  input  logic [SEQ_W-1:0]        tx_stamp,
  input  logic                    tx_end,
  input  logic                    lg_valid,
  input  logic [SLOT_W-1:0]       lg_slot,
  input  logic [LINE_W-1:0]       lg_line,
  input  logic [GUARD_MASK_W-1:0] lg_mask,
  input  logic                    lg_write,
  output logic                    bcast_req,
  input  logic                    rep_valid,
  input  logic                    rep_grant,
  output logic                    guard_ok,
  output logic                    guard_abort,
  output logic                    abort_lost,
  output logic                    txn_active,
  input  logic                    in_valid,
  input  logic [ID_W-1:0]         in_src,
  input  logic [LINE_W-1:0]       in_line,
  input  logic [GUARD_MASK_W-1:0] in_mask,
  input  logic                    in_write,
  input  logic [SEQ_W-1:0]        in_stamp,
  output logic                    rsp_valid,
  output logic [ID_W-1:0]         rsp_dst,
  output logic                    rsp_grant
);
  logic              active;
  logic [SEQ_W-1:0]  my_stamp;
  logic [SLOT_W-1:0] pend_slot;
  logic collide, covered, busy, fin, fin_deny;
  logic we_older, lost, clear, accept, hit, launch;

  assign we_older = my_stamp < in_stamp;
  assign lost     = active && in_valid && collide && !we_older;
  assign clear    = tx_begin || lost || fin_deny || tx_end;
  assign accept   = active && lg_valid && !busy && !clear;
  assign hit      = accept && covered;
  assign launch   = accept && !covered;

  guard_table #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_table (
    .clk(clk), .rst(rst), .clr(clear),
    .wr_en(launch), .wr_slot(lg_slot), .wr_line(lg_line),
    .wr_mask(lg_mask), .wr_excl(lg_write),
    .promote(fin && !fin_deny), .promote_slot(pend_slot),
    .pq_line(in_line), .pq_mask(in_mask), .pq_excl(in_write), .pq_collide(collide),
    .lq_line(lg_line), .lq_mask(lg_mask), .lq_covered(covered)
  );

  reply_tally #(.PEERS(PEERS)) u_tally (
    .clk(clk), .rst(rst), .clr(clear), .start(launch),
    .rep_valid(rep_valid), .rep_grant(rep_grant),
    .busy(busy), .fin(fin), .fin_deny(fin_deny)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      my_stamp    <= '0;
      pend_slot   <= '0;
      rsp_valid   <= 1'b0;
      rsp_dst     <= '0;
      rsp_grant   <= 1'b0;
      guard_ok    <= 1'b0;
      guard_abort <= 1'b0;
      abort_lost  <= 1'b0;
      bcast_req   <= 1'b0;
    end else begin
      rsp_valid   <= in_valid;
      rsp_dst     <= in_src;
      rsp_grant   <= in_valid && !(active && collide && we_older);
      guard_ok    <= !clear && ((fin && !fin_deny) || hit);
      guard_abort <= !tx_begin && (lost || fin_deny);
      abort_lost  <= !tx_begin && lost;
      bcast_req   <= launch;
      if (launch) pend_slot <= lg_slot;
      if (tx_begin) begin
        active   <= 1'b1;
        my_stamp <= tx_stamp;
      end else if (lost || fin_deny || tx_end) begin
        active <= 1'b0;
      end
    end
  end

  assign txn_active = active;
endmodule

// File: rtl/guard_responder_chk.sv
module guard_responder_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [ID_W-1:0] in_src,
  input logic            rsp_valid,
  input logic [ID_W-1:0] rsp_dst,
  input logic            rsp_grant,
  input logic            lg_valid,
  input logic            bcast_req,
  input logic            guard_ok,
  input logic            guard_abort,
  input logic            txn_active
);
  // R2
  one_reply_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (rsp_valid && rsp_dst == $past(in_src)));
  // R2
  no_spurious_reply_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !rsp_valid);
  // R5
  deny_needs_txn_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_grant) |-> $past(txn_active));
  // R6
  abort_ends_txn_chk: assert property (@(posedge clk) disable iff (rst)
    guard_abort |-> !txn_active);
  // R8
  ok_abort_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(guard_ok && guard_abort));
  // R7
  bcast_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bcast_req |-> $past(lg_valid));
endmodule

bind guard_responder guard_responder_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
  .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_grant(rsp_grant),
  .lg_valid(lg_valid), .bcast_req(bcast_req), .guard_ok(guard_ok),
  .guard_abort(guard_abort), .txn_active(txn_active)
);

// File: tb/tb_guard_responder.sv
module tb_guard_responder;
  localparam int ID_W = 4, LINE_W = 26, SEQ_W = 8, ENTRIES = 4, PEERS = 3, SLOT_W = 2;
  localparam logic [LINE_W-1:0] LA = 26'h100, LB = 26'h101, LC = 26'h2AA, LD = 26'h333;

  logic clk = 0, rst = 1;
  logic tx_begin = 0, tx_end = 0, lg_valid = 0, lg_write = 0, rep_valid = 0, rep_grant = 0;
  logic in_valid = 0, in_write = 0;
  logic [SEQ_W-1:0] tx_stamp = 0, in_stamp = 0;
  logic [SLOT_W-1:0] lg_slot = 0;
  logic [LINE_W-1:0] lg_line = 0, in_line = 0;
  logic [63:0] lg_mask = 0, in_mask = 0;
  logic [ID_W-1:0] in_src = 0;
  logic bcast_req, guard_ok, guard_abort, abort_lost, txn_active, rsp_valid, rsp_grant;
  logic [ID_W-1:0] rsp_dst;
  int checks = 0, failures = 0;
  bit finished = 0;

  // reference table for the random phase
  logic [LINE_W-1:0] m_line [3];
  logic [63:0] m_mask [3];
  logic m_wr [3];

  always #5 clk = ~clk;

  guard_responder #(.ID_W(ID_W), .LINE_W(LINE_W), .SEQ_W(SEQ_W), .ENTRIES(ENTRIES), .PEERS(PEERS)) dut (
    .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_stamp(tx_stamp), .tx_end(tx_end),
    .lg_valid(lg_valid), .lg_slot(lg_slot), .lg_line(lg_line), .lg_mask(lg_mask), .lg_write(lg_write),
    .bcast_req(bcast_req), .rep_valid(rep_valid), .rep_grant(rep_grant),
    .guard_ok(guard_ok), .guard_abort(guard_abort), .abort_lost(abort_lost), .txn_active(txn_active),
    .in_valid(in_valid), .in_src(in_src), .in_line(in_line), .in_mask(in_mask),
    .in_write(in_write), .in_stamp(in_stamp),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_grant(rsp_grant));

  function automatic bit model_grant(logic [LINE_W-1:0] l, logic [63:0] m, logic w);
    for (int k = 0; k < 3; k++)
      if (m_line[k] == l && (|(m_mask[k] & m)) && (m_wr[k] || w)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_in(logic [ID_W-1:0] s, logic [LINE_W-1:0] l, logic [63:0] m, logic w, logic [SEQ_W-1:0] st);
    in_valid = 1; in_src = s; in_line = l; in_mask = m; in_write = w; in_stamp = st;
    tick();
    in_valid = 0;
  endtask

  task automatic guard(logic [SLOT_W-1:0] sl, logic [LINE_W-1:0] l, logic [63:0] m, logic w);
    lg_valid = 1; lg_slot = sl; lg_line = l; lg_mask = m; lg_write = w;
    tick();
    lg_valid = 0;
  endtask

  task automatic reply(logic g);
    rep_valid = 1; rep_grant = g;
    tick();
    rep_valid = 0;
  endtask

  task automatic begin_tx(logic [SEQ_W-1:0] st);
    tx_begin = 1; tx_stamp = st;
    tick();
    tx_begin = 0;
  endtask

  task automatic install(logic [SLOT_W-1:0] sl, logic [LINE_W-1:0] l, logic [63:0] m, logic w);
    guard(sl, l, m, w);
    chk(bcast_req == 1, "R7 bcast", bcast_req, 1);
    reply(1); reply(1);
    chk(guard_ok == 0, "R8 early ok", guard_ok, 0);
    reply(1);
    chk(guard_ok == 1, "R8 ok after all", guard_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    repeat (3) tick();
    rst = 0;
    chk({rsp_valid, rsp_grant, guard_ok, guard_abort, abort_lost, bcast_req, txn_active} == 0,
        "R1 reset", {rsp_valid, rsp_grant, guard_ok, guard_abort, abort_lost, bcast_req, txn_active}, 0);

    begin_tx(8'h10);
    install(0, LA, 64'h00FF, 0);
    install(1, LB, 64'hFF00, 1);

    send_in(4'd3, LA, 64'h000F, 0, 8'h20);
    chk(rsp_valid && rsp_grant, "R3 read share", rsp_grant, 1);
    chk(rsp_dst == 4'd3, "R2 dst", rsp_dst, 3);
    send_in(4'd5, LA, 64'h0001, 1, 8'h20);
    chk(rsp_grant == 0, "R4 write on read", rsp_grant, 0);
    send_in(4'd6, LB, 64'h0100, 0, 8'h20);
    chk(rsp_grant == 0, "R4 read on write", rsp_grant, 0);
    send_in(4'd6, LB, 64'h00FF, 1, 8'h20);
    chk(rsp_grant == 1, "R5 disjoint bytes", rsp_grant, 1);
    send_in(4'd2, LC, 64'hFFFF, 1, 8'h20);
    chk(rsp_grant == 1, "R5 other line", rsp_grant, 1);
    chk(txn_active == 1, "R4 local survives", txn_active, 1);

    guard(2, LB, 64'h0300, 1);
    chk(guard_ok == 1 && bcast_req == 0, "R10 covered guard", {guard_ok, bcast_req}, 2'b10);

    reply(0);
    chk(guard_ok == 0 && guard_abort == 0, "R12 stray reply", {guard_ok, guard_abort}, 0);
    guard(2, LC, 64'h0001, 0);
    chk(bcast_req == 1, "R7 bcast C", bcast_req, 1);
    reply(1); reply(1);
    chk(guard_ok == 0, "R12 count not advanced", guard_ok, 0);
    reply(1);
    chk(guard_ok == 1, "R8 ok C", guard_ok, 1);

    m_line[0] = LA; m_mask[0] = 64'h00FF; m_wr[0] = 0;
    m_line[1] = LB; m_mask[1] = 64'hFF00; m_wr[1] = 1;
    m_line[2] = LC; m_mask[2] = 64'h0001; m_wr[2] = 0;
    for (int i = 0; i < 300; i++) begin
      logic [LINE_W-1:0] l;
      logic [63:0] m;
      logic w;
      logic [ID_W-1:0] s;
      case ($urandom_range(0, 3))
        0: l = LA; 1: l = LB; 2: l = LC; default: l = LD;
      endcase
      m = {32'h0, $urandom() & $urandom() & $urandom()};
      w = 1'($urandom_range(0, 1));
      s = ID_W'($urandom());
      send_in(s, l, m, w, 8'($urandom_range(8'h11, 8'hFF)));
      chk(rsp_valid && rsp_dst == s, "R2 random reply", {rsp_valid, rsp_dst}, {1'b1, s});
      chk(rsp_grant == model_grant(l, m, w), "R3/R4/R5 random verdict", rsp_grant, model_grant(l, m, w));
    end
    tick();
    chk(rsp_valid == 0, "R2 idle", rsp_valid, 0);

    guard(3, LD, 64'h1, 0);
    reply(1); reply(0);
    chk(guard_abort == 0, "R9 wait all", guard_abort, 0);
    reply(1);
    chk(guard_abort && !abort_lost && !txn_active, "R9 deny abort",
        {guard_abort, abort_lost, txn_active}, 3'b100);
    send_in(4'd1, LA, 64'hFFFF, 1, 8'h20);
    chk(rsp_grant == 1, "R9 table cleared", rsp_grant, 1);

    begin_tx(8'h80);
    install(0, LA, 64'h00F0, 1);
    send_in(4'd7, LA, 64'h0010, 0, 8'h40);
    chk(rsp_grant == 1, "R6 older peer granted", rsp_grant, 1);
    chk(guard_abort && abort_lost && !txn_active, "R6 lost abort",
        {guard_abort, abort_lost, txn_active}, 3'b110);

    begin_tx(8'h00);
    install(1, LB, 64'hFFFF, 1);
    tx_end = 1; tick(); tx_end = 0;
    chk(txn_active == 0, "R11 inactive", txn_active, 0);
    send_in(4'd4, LB, 64'h0F0F, 1, 8'h90);
    chk(rsp_grant == 1, "R11 released", rsp_grant, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule